// File: doc/BRIEF.md
# Capture/Compare Timer

A peripheral timer built on a free-running 16-bit counter that advances once per prescaler tick and wraps from 0xFFFF to 0x0000. Nothing ever reloads or clears it. Two registers share this time base. An input-capture register takes a snapshot of the counter when the chosen edge arrives on an asynchronous capture pin. An output-compare register is checked against every new counter value. On a match, the block sets a flag and drives a dedicated output pin to a level that software chose beforehand.

Software reaches the block through an 8-bit register bus with eight addresses. A counter read is coherent: reading the high byte freezes the low byte in a buffer, and a later low-byte read returns that frozen value. The capture, compare and overflow events each set a sticky flag. Software clears a flag by writing 1 to it. Each flag has an enable bit, and the enabled flags are combined into one interrupt request.

Top module: `cap_cmp_timer`

## Requirements
- R1: After a synchronous reset, the counter, capture register, control register, flags, `cmp_out` and `irq` are all zero, and the compare register is 0xFFFF.
- R2: The counter adds one on every prescaler tick, which comes every `DIV` clocks (default 1). It wraps from 0xFFFF to 0x0000 and is not cleared by a compare match.
- R3: Reading address 0 returns the counter's upper byte and copies its lower byte into a buffer. Reading address 1 returns that buffer, unchanged by later counting.
- R4: Control bit 0 selects the capture edge: 1 for rising, 0 for falling. The opposite edge does nothing. The capture pin passes through a two-flop synchroniser, so the stored value is the counter value two clocks after the first clock edge that sees the new level. The capture register is read at address 2 (high byte) and address 3 (low byte).
- R5: A capture sets flag bit 1 in the same clock edge that loads the capture register.
- R6: The compare register is written at address 4 (high byte) and address 5 (low byte). Flag bit 0 is set at the clock edge where the counter takes a value equal to the compare register.
- R7: On each match, `cmp_out` takes the value of control bit 1. Between matches it holds its level, whatever happens to control bit 1.
- R8: Flag bit 2 is set at the clock edge where the counter wraps from 0xFFFF to 0x0000.
- R9: The flag register sits at address 7. Writing 1 to a bit clears that flag, and writing 0 leaves it as it is. A set event in the same cycle as a clear takes priority.
- R10: The control register sits at address 6. Bits 2, 3 and 4 enable flags 0, 1 and 2. `irq` is high exactly when some flag is set and its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of address 0 latches the low counter byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| cap_in | input | 1 | Asynchronous capture event input |
| cmp_out | output | 1 | Output driven to the programmed level on compare match |
| irq | output | 1 | Interrupt request |

## Verification
The bench times the capture latency exactly. A design with one synchroniser stage too many or too few stores a counter value that is off by one. The bench gives each edge polarity the edge it must ignore; a design that captures on both edges raises the capture flag too soon. It holds the low byte in the buffer across hundreds of counts; a design that returns the live counter byte fails there. It watches `cmp_out` and `irq` in the cycle before and the cycle of a match and of the 0xFFFF wrap, which catches a match taken one count late, a pin that follows the control bit instead of the match, and an overflow taken on the wrong edge. It also writes 0 to a set flag, which catches a design that clears flags on any write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned CNT_W  = 16;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned NFLAG  = 3;

    localparam int unsigned F_CMP = 0;
    localparam int unsigned F_CAP = 1;
    localparam int unsigned F_OVF = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_CNT_HI = 3'd0,
        RA_CNT_LO = 3'd1,
        RA_CAP_HI = 3'd2,
        RA_CAP_LO = 3'd3,
        RA_CMP_HI = 3'd4,
        RA_CMP_LO = 3'd5,
        RA_CTRL   = 3'd6,
        RA_FLAGS  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [NFLAG-1:0] ie;
        logic             cmp_lvl;
        logic             cap_rise;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  cap;
        logic [CNT_W-1:0]  cmp;
        logic [DATA_W-1:0] lo_buf;
        ctrl_t             ctrl;
        logic [NFLAG-1:0]  flags;
        logic              cmp_out;
    } tmr_state_t;

endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
    parameter int unsigned DIV = 1
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pc_d, pc_q;

    always_comb begin
        pc_d = (pc_q == LAST) ? '0 : pc_q + 1'b1;
        tick = (pc_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic rise_sel,
    output logic hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    genvar i;
    generate
        for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    sync_q[i] <= 1'b0;
                else if (i == 0)
                    sync_q[i] <= din;
                else
                    sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    always_comb begin
        if (rise_sel) hit = sync_q[SYNC_STAGES-1] & ~prev_q;
        else          hit = ~sync_q[SYNC_STAGES-1] & prev_q;
    end
endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
    import tmr_pkg::*;
#(
    parameter int unsigned DIV         = 1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_in,
    output logic              cmp_out,
    output logic              irq
);
    localparam int unsigned CW = $bits(ctrl_t);

    tmr_state_t       s_d, s_q;
    logic             tick;
    logic             cap_hit;
    logic             match;
    logic             wrap;
    logic [CNT_W-1:0] cnt_inc;

    tmr_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .din      (cap_in),
        .rise_sel (s_q.ctrl.cap_rise),
        .hit      (cap_hit)
    );

    always_comb begin
        s_d     = s_q;
        cnt_inc = s_q.cnt + 1'b1;
        match   = 1'b0;
        wrap    = 1'b0;

        if (tick) begin
            s_d.cnt = cnt_inc;
            match   = (cnt_inc == s_q.cmp);
            wrap    = (s_q.cnt == '1);
        end

        if (bus_rd && (bus_addr == RA_CNT_HI))
            s_d.lo_buf = s_q.cnt[DATA_W-1:0];

        if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                RA_CMP_HI: s_d.cmp[CNT_W-1 -: DATA_W] = bus_wdata;
                RA_CMP_LO: s_d.cmp[DATA_W-1:0]        = bus_wdata;
                RA_CTRL:   s_d.ctrl                   = ctrl_t'(bus_wdata[CW-1:0]);
                RA_FLAGS:  s_d.flags = s_q.flags & ~bus_wdata[NFLAG-1:0];
                default: ;
            endcase
        end

        if (cap_hit) begin
            s_d.cap          = s_q.cnt;
            s_d.flags[F_CAP] = 1'b1;
        end
        if (match) begin
            s_d.flags[F_CMP] = 1'b1;
            s_d.cmp_out      = s_q.ctrl.cmp_lvl;
        end
        if (wrap)
            s_d.flags[F_OVF] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q     <= '0;
            s_q.cmp <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (reg_addr_e'(bus_addr))
            RA_CNT_HI: bus_rdata = s_q.cnt[CNT_W-1 -: DATA_W];
            RA_CNT_LO: bus_rdata = s_q.lo_buf;
            RA_CAP_HI: bus_rdata = s_q.cap[CNT_W-1 -: DATA_W];
            RA_CAP_LO: bus_rdata = s_q.cap[DATA_W-1:0];
            RA_CMP_HI: bus_rdata = s_q.cmp[CNT_W-1 -: DATA_W];
            RA_CMP_LO: bus_rdata = s_q.cmp[DATA_W-1:0];
            RA_CTRL:   bus_rdata = DATA_W'(s_q.ctrl);
            default:   bus_rdata = DATA_W'(s_q.flags);
        endcase
        cmp_out = s_q.cmp_out;
        irq     = |(s_q.flags & s_q.ctrl.ie);
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp,
    input logic [W-1:0] cap,
    input logic [2:0]   flags,
    input logic         cmp_out,
    input logic         clr_cmp
);
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == W'($past(cnt) + 1'b1)));

    // R6
    cmp_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[0]) |-> (cnt == $past(cmp)));

    // R7
    cmp_pin_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmp_out) |-> (cnt == $past(cmp)));

    // R5
    cap_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[1]) |-> (cap == $past(cnt)));

    // R8
    ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[2]) |-> (cnt == '0));

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && !clr_cmp) |=> flags[0]);
endmodule

bind cap_cmp_timer tmr_chk #(.W(tmr_pkg::CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cnt     (s_q.cnt),
    .cmp     (s_q.cmp),
    .cap     (s_q.cap),
    .flags   (s_q.flags),
    .cmp_out (s_q.cmp_out),
    .clr_cmp (bus_wr && (bus_addr == 3'd7) && bus_wdata[0])
);

// File: tb/tb_cap_cmp_timer.sv
module tb_cap_cmp_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_in = 1'b0;
    logic       cmp_out;
    logic       irq;

    int         n_chk = 0;
    int         n_err = 0;
    logic [15:0] m;   // expected counter value (one count per clock)

    cap_cmp_timer dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) m <= '0;
        else     m <= m + 16'd1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic [15:0] snap);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata; snap = m;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_m(input logic [15:0] v);
        while (m != v) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic [15:0] s;
        chk(cmp_out == 1'b0, "R1 cmp_out", cmp_out, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        rd(3'd7, d, s); chk(d == 8'h00, "R1 flags", d, 0);
        rd(3'd6, d, s); chk(d == 8'h00, "R1 ctrl", d, 0);
        rd(3'd4, d, s); chk(d == 8'hFF, "R1 cmp hi", d, 8'hFF);
        rd(3'd5, d, s); chk(d == 8'hFF, "R1 cmp lo", d, 8'hFF);
        rd(3'd3, d, s); chk(d == 8'h00, "R1 cap lo", d, 0);
        rd(3'd0, d, s); chk(d == s[15:8], "R1 counter hi", d, s[15:8]);
    endtask

    task automatic t_read_latch();
        logic [7:0] hi, lo; logic [15:0] s, s2;
        rd(3'd0, hi, s);
        repeat (300) @(negedge clk);
        rd(3'd1, lo, s2);
        chk(hi == s[15:8], "R3 hi byte", hi, s[15:8]);
        chk(lo == s[7:0], "R3 buffered lo byte", lo, s[7:0]);
    endtask

    task automatic t_compare();
        logic [7:0] d; logic [15:0] s, tgt;
        wr(3'd6, 8'h06);           // level 1, enable compare flag
        wr(3'd7, 8'h07);
        @(negedge clk); tgt = m + 16'd40;
        wr(3'd4, tgt[15:8]);
        wr(3'd5, tgt[7:0]);
        wait_m(tgt - 16'd1);
        chk(cmp_out == 1'b0, "R7 pin before match", cmp_out, 0);
        chk(irq == 1'b0, "R6 no flag before match", irq, 0);
        @(negedge clk);
        chk(cmp_out == 1'b1, "R7 pin at match", cmp_out, 1);
        chk(irq == 1'b1, "R10 irq on compare", irq, 1);
        rd(3'd7, d, s); chk(d[0] == 1'b1, "R6 compare flag", d, 1);
        rd(3'd0, d, s); chk(d == s[15:8], "R2 counter runs past match", d, s[15:8]);
        // R9: writing 0 keeps the flag, writing 1 clears it
        wr(3'd7, 8'h00);
        rd(3'd7, d, s); chk(d[0] == 1'b1, "R9 write 0 keeps flag", d, 1);
        wr(3'd7, 8'h01);
        rd(3'd7, d, s); chk(d[0] == 1'b0, "R9 write 1 clears flag", d, 0);
        chk(irq == 1'b0, "R10 irq drops", irq, 0);
        // second match with level 0
        wr(3'd6, 8'h04);
        @(negedge clk); tgt = m + 16'd40;
        wr(3'd4, tgt[15:8]);
        wr(3'd5, tgt[7:0]);
        wait_m(tgt - 16'd1);
        chk(cmp_out == 1'b1, "R7 pin holds until match", cmp_out, 1);
        @(negedge clk);
        chk(cmp_out == 1'b0, "R7 pin driven low at match", cmp_out, 0);
        wr(3'd7, 8'h07);
    endtask

    task automatic t_cap_rise();
        logic [7:0] hi, lo, d; logic [15:0] s, m0;
        wr(3'd6, 8'h09);            // rising, capture enable
        wr(3'd7, 8'h07);
        @(negedge clk); cap_in = 1'b1; m0 = m;
        repeat (4) @(negedge clk);
        chk(irq == 1'b1, "R10 irq on capture", irq, 1);
        rd(3'd7, d, s); chk(d[1] == 1'b1, "R5 capture flag", d, 2);
        rd(3'd2, hi, s); rd(3'd3, lo, s);
        chk({hi, lo} == m0 + 16'd2, "R4 rising capture value", {hi, lo}, m0 + 16'd2);
        wr(3'd7, 8'h02);
        @(negedge clk); cap_in = 1'b0;
        repeat (5) @(negedge clk);
        rd(3'd7, d, s); chk(d[1] == 1'b0, "R4 falling edge ignored", d, 0);
        rd(3'd2, hi, s); rd(3'd3, lo, s);
        chk({hi, lo} == m0 + 16'd2, "R4 capture unchanged", {hi, lo}, m0 + 16'd2);
    endtask

    task automatic t_cap_fall();
        logic [7:0] hi, lo, d; logic [15:0] s, m0;
        wr(3'd6, 8'h08);            // falling, capture enable
        wr(3'd7, 8'h07);
        @(negedge clk); cap_in = 1'b1;
        repeat (5) @(negedge clk);
        rd(3'd7, d, s); chk(d[1] == 1'b0, "R4 rising ignored in falling mode", d, 0);
        @(negedge clk); cap_in = 1'b0; m0 = m;
        repeat (4) @(negedge clk);
        rd(3'd7, d, s); chk(d[1] == 1'b1, "R5 capture flag falling", d, 2);
        rd(3'd2, hi, s); rd(3'd3, lo, s);
        chk({hi, lo} == m0 + 16'd2, "R4 falling capture value", {hi, lo}, m0 + 16'd2);
    endtask

    task automatic t_overflow();
        logic [7:0] d; logic [15:0] s;
        wr(3'd6, 8'h10);            // overflow enable only
        wr(3'd7, 8'h07);
        wait_m(16'hFFFF);
        chk(irq == 1'b0, "R8 no overflow before wrap", irq, 0);
        @(negedge clk);
        chk(irq == 1'b1, "R8 overflow at wrap", irq, 1);
        rd(3'd7, d, s); chk(d[2] == 1'b1, "R8 overflow flag", d, 4);
        rd(3'd0, d, s); chk(d == s[15:8], "R2 counter after wrap", d, s[15:8]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_latch();
        t_compare();
        t_cap_rise();
        t_cap_fall();
        t_overflow();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule